// File: doc/BRIEF.md
# Superscalar In-Order Issue Checker

This block sits in the decode stage of an in-order superscalar core that decodes up to N instructions per cycle. N can be 2 to 4. Each decoded slot can have two source registers and one target register, and each of these operands has its own valid flag. Each slot also names the functional-unit class it needs. The block compares every slot against the slots ahead of it in the same group and against a pending-write scoreboard that tracks instructions already issued and still in flight. It also checks a per-class mask of free units. It reports how many instructions from the front of the group may issue this cycle.

The scoreboard is held inside the block and has one pending bit per architectural register. An instruction that issues marks its target as pending. A completing writeback, signalled on one of the writeback ports, clears the bit. Register zero can be configured as a hardwired constant, and then it never takes part in a dependence. The issue count is combinational from the current inputs and the registered scoreboard. The scoreboard update takes effect at the next clock edge.

Top module: `issue_checker`

## Requirements
- R1: `issue_cnt` equals the index of the first slot, counted from slot 0, that is invalid (`slot_vld` bit 0) or fails any check. When every slot passes, it equals N. No slot after a stalled one issues.
- R2: A slot stalls when a live source equals the live target of an earlier slot in the same group (read-after-write).
- R3: A slot stalls when its live target equals the live target of an earlier slot in the same group (write-after-write).
- R4: A slot stalls when its live target equals a live source of an earlier slot in the same group (write-after-read).
- R5: A slot stalls when any of its live sources, or its live target, has its pending bit set in the scoreboard.
- R6: A slot with class code c stalls when `unit_free[c]` is 0. It also stalls when an earlier slot in the group uses the same class, because each class accepts at most one instruction per cycle.
- R7: The scoreboard is all zeros after reset. At each clock edge, the live targets of the issued slots set their bits and valid writeback ports clear theirs. When a clear and a set hit the same register in one cycle, the set wins.
- R8: A source or target whose own valid flag is 0 takes part in no comparison and sets no scoreboard bit.
- R9: With `R0_HARDWIRED` = 1, register 0 creates no dependence of any kind and its pending bit stays 0.
- R10: A writeback that clears a pending register does not release a slot that reads that register in the same cycle. The slot can issue in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | N | Slot i holds a decoded instruction |
| slot_src_a | input | N*RW | First source register of each slot, slot i at bits [i*RW +: RW] |
| slot_src_a_vld | input | N | First source is used |
| slot_src_b | input | N*RW | Second source register of each slot |
| slot_src_b_vld | input | N | Second source is used |
| slot_dst | input | N*RW | Target register of each slot |
| slot_dst_vld | input | N | Target is written |
| slot_cls | input | N*CW | Functional-unit class code of each slot |
| unit_free | input | NCLASS | Bit c set: a unit of class c can accept an instruction |
| wb_vld | input | WB | Writeback port k completes this cycle |
| wb_reg | input | WB*RW | Register cleared by writeback port k |
| issue_cnt | output | CNTW | Number of slots from the front that issue |
| pending | output | NREG | Scoreboard: register has an in-flight write |

## Verification
The bench uses directed groups that separate the hazard kinds from one another:
- a fully independent group, which should issue in full;
- groups with a single read-after-write, write-after-write or write-after-read pair at a chosen distance, where the stall position shows which comparator fired;
- groups whose only conflict is with an in-flight register, or with a busy or doubled unit class.

Further groups pair a matching register with a cleared valid flag, or use register zero, to show that these comparisons are suppressed. A writeback landing in the same cycle as a dependent read separates registered-scoreboard behaviour from bypassing, and a spurious writeback on a freshly issued target shows set-over-clear priority. A long random phase draws registers from a small range so that overlapping hazards happen often, and a behavioural model checks both outputs every cycle.

// File: rtl/issue_pkg.sv
package issue_pkg;

    // Outcome of comparing one later slot against one earlier slot
    typedef struct packed {
        logic raw;   // later source reads earlier target
        logic waw;   // both write the same target
        logic war;   // later target overwrites earlier source
        logic unit;  // both need the same unit class
    } pair_hz_t;

endpackage

// File: rtl/issue_pair_check.sv
module issue_pair_check
    import issue_pkg::*;
#(
    parameter int RW = 5,
    parameter int CW = 2
) (
    input  logic [RW-1:0] late_sa,
    input  logic          late_sa_live,
    input  logic [RW-1:0] late_sb,
    input  logic          late_sb_live,
    input  logic [RW-1:0] late_dst,
    input  logic          late_dst_live,
    input  logic [CW-1:0] late_cls,
    input  logic [RW-1:0] early_sa,
    input  logic          early_sa_live,
    input  logic [RW-1:0] early_sb,
    input  logic          early_sb_live,
    input  logic [RW-1:0] early_dst,
    input  logic          early_dst_live,
    input  logic [CW-1:0] early_cls,
    output pair_hz_t      hz
);
    always_comb begin
        hz.raw  = early_dst_live &
                  ((late_sa_live & (late_sa == early_dst)) |
                   (late_sb_live & (late_sb == early_dst)));
        hz.waw  = early_dst_live & late_dst_live & (late_dst == early_dst);
        hz.war  = late_dst_live &
                  ((early_sa_live & (early_sa == late_dst)) |
                   (early_sb_live & (early_sb == late_dst)));
        hz.unit = (late_cls == early_cls);
    end
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
    parameter int NREG         = 32,
    parameter int WB           = 2,
    parameter bit R0_HARDWIRED = 1'b1,
    localparam int RW          = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG-1:0]    set_vec,
    input  logic [WB-1:0]      wb_vld,
    input  logic [WB*RW-1:0]   wb_reg,
    output logic [NREG-1:0]    pending
);
    typedef struct packed {
        logic [NREG-1:0] pend;
    } sb_state_t;

    sb_state_t sb_d, sb_q;
    logic [NREG-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        for (int k = 0; k < WB; k++) begin
            if (wb_vld[k]) clr_vec[wb_reg[k*RW +: RW]] = 1'b1;
        end
        // set has priority over clear
        sb_d.pend = (sb_q.pend & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign pending = sb_q.pend;

    // R7: every bit set by an issue is pending on the next cycle
    a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & $past(set_vec)) == $past(set_vec)));

    // R7: a cleared bit with no competing set is gone on the next cycle
    a_r7_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & $past(clr_vec & ~set_vec)) == '0));

    generate
        if (R0_HARDWIRED) begin : g_zero_chk
            // R9: register zero never becomes pending
            a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !pending[0]);
        end
    endgenerate
endmodule

// File: rtl/issue_checker.sv
module issue_checker
    import issue_pkg::*;
#(
    parameter int N            = 4,
    parameter int NREG         = 32,
    parameter int NCLASS       = 4,
    parameter int WB           = 2,
    parameter bit R0_HARDWIRED = 1'b1,
    localparam int RW          = $clog2(NREG),
    localparam int CW          = $clog2(NCLASS),
    localparam int CNTW        = $clog2(N + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       slot_vld,
    input  logic [N*RW-1:0]    slot_src_a,
    input  logic [N-1:0]       slot_src_a_vld,
    input  logic [N*RW-1:0]    slot_src_b,
    input  logic [N-1:0]       slot_src_b_vld,
    input  logic [N*RW-1:0]    slot_dst,
    input  logic [N-1:0]       slot_dst_vld,
    input  logic [N*CW-1:0]    slot_cls,
    input  logic [NCLASS-1:0]  unit_free,
    input  logic [WB-1:0]      wb_vld,
    input  logic [WB*RW-1:0]   wb_reg,
    output logic [CNTW-1:0]    issue_cnt,
    output logic [NREG-1:0]    pending
);
    logic [N-1:0] sa_live, sb_live, dst_live, slot_ok;
    pair_hz_t     hz [N*N];
    logic [NREG-1:0] set_vec;

    // Operand liveness: valid flag, and not the hardwired zero register
    always_comb begin
        for (int i = 0; i < N; i++) begin
            sa_live[i]  = slot_src_a_vld[i] &
                          ~(R0_HARDWIRED && (slot_src_a[i*RW +: RW] == '0));
            sb_live[i]  = slot_src_b_vld[i] &
                          ~(R0_HARDWIRED && (slot_src_b[i*RW +: RW] == '0));
            dst_live[i] = slot_dst_vld[i] &
                          ~(R0_HARDWIRED && (slot_dst[i*RW +: RW] == '0));
        end
    end

    // One comparator set for each (later, earlier) pair
    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_late
            for (genvar gj = 0; gj < N; gj++) begin : g_early
                if (gj < gi) begin : g_pair
                    issue_pair_check #(.RW(RW), .CW(CW)) u_pair (
                        .late_sa       (slot_src_a[gi*RW +: RW]),
                        .late_sa_live  (sa_live[gi]),
                        .late_sb       (slot_src_b[gi*RW +: RW]),
                        .late_sb_live  (sb_live[gi]),
                        .late_dst      (slot_dst[gi*RW +: RW]),
                        .late_dst_live (dst_live[gi]),
                        .late_cls      (slot_cls[gi*CW +: CW]),
                        .early_sa      (slot_src_a[gj*RW +: RW]),
                        .early_sa_live (sa_live[gj]),
                        .early_sb      (slot_src_b[gj*RW +: RW]),
                        .early_sb_live (sb_live[gj]),
                        .early_dst     (slot_dst[gj*RW +: RW]),
                        .early_dst_live(dst_live[gj]),
                        .early_cls     (slot_cls[gj*CW +: CW]),
                        .hz            (hz[gi*N + gj])
                    );
                end else begin : g_none
                    assign hz[gi*N + gj] = '0;
                end
            end
        end
    endgenerate

    // Per-slot pass/fail against the group, the scoreboard and the units
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = ~unit_free[slot_cls[i*CW +: CW]];
            blocked |= sa_live[i]  & pending[slot_src_a[i*RW +: RW]];
            blocked |= sb_live[i]  & pending[slot_src_b[i*RW +: RW]];
            blocked |= dst_live[i] & pending[slot_dst[i*RW +: RW]];
            for (int j = 0; j < N; j++) begin
                if (j < i) blocked |= |hz[i*N + j];
            end
            slot_ok[i] = slot_vld[i] & ~blocked;
        end
    end

    // In-order cut: count passing slots up to the first failure
    always_comb begin
        logic stop;
        stop      = 1'b0;
        issue_cnt = '0;
        set_vec   = '0;
        for (int i = 0; i < N; i++) begin
            if (!stop && slot_ok[i]) begin
                issue_cnt = CNTW'(i + 1);
                if (dst_live[i]) set_vec[slot_dst[i*RW +: RW]] = 1'b1;
            end else begin
                stop = 1'b1;
            end
        end
    end

    issue_scoreboard #(.NREG(NREG), .WB(WB), .R0_HARDWIRED(R0_HARDWIRED)) u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .wb_vld (wb_vld),
        .wb_reg (wb_reg),
        .pending(pending)
    );

    // R1: the count never exceeds the group width
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        issue_cnt <= CNTW'(N));

    // R1: anything issuing means the head slot holds an instruction
    a_r1_head_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt != '0) |-> slot_vld[0]);

    // R5: an issuing head never reads a pending register
    a_r5_head_src_free: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_cnt != '0) && sa_live[0]) |-> !pending[slot_src_a[RW-1:0]]);

    // R6: an issuing head always has a free unit of its class
    a_r6_head_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt != '0) |-> unit_free[slot_cls[CW-1:0]]);
endmodule

// File: tb/issue_checker_tb.sv
module issue_checker_tb_top;
    localparam int N = 4, NREG = 32, NCLASS = 4, WB = 2, RW = 5, CW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [RW-1:0] sa [N], sb [N], dd [N];
    logic          sav [N], sbv [N], dv [N], v [N];
    logic [CW-1:0] cls [N];
    logic [NCLASS-1:0] free;
    logic          wbv [WB];
    logic [RW-1:0] wbr [WB];

    logic [N-1:0]      slot_vld, slot_src_a_vld, slot_src_b_vld, slot_dst_vld;
    logic [N*RW-1:0]   slot_src_a, slot_src_b, slot_dst;
    logic [N*CW-1:0]   slot_cls;
    logic [WB-1:0]     wb_vld;
    logic [WB*RW-1:0]  wb_reg;
    logic [2:0]        issue_cnt;
    logic [NREG-1:0]   pending;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            slot_vld[i] = v[i];
            slot_src_a[i*RW +: RW] = sa[i];  slot_src_a_vld[i] = sav[i];
            slot_src_b[i*RW +: RW] = sb[i];  slot_src_b_vld[i] = sbv[i];
            slot_dst[i*RW +: RW]   = dd[i];  slot_dst_vld[i]   = dv[i];
            slot_cls[i*CW +: CW]   = cls[i];
        end
        for (int k = 0; k < WB; k++) begin
            wb_vld[k] = wbv[k];
            wb_reg[k*RW +: RW] = wbr[k];
        end
    end

    issue_checker dut_i (
        .clk(clk), .rst_n(rst_n),
        .slot_vld(slot_vld),
        .slot_src_a(slot_src_a), .slot_src_a_vld(slot_src_a_vld),
        .slot_src_b(slot_src_b), .slot_src_b_vld(slot_src_b_vld),
        .slot_dst(slot_dst), .slot_dst_vld(slot_dst_vld),
        .slot_cls(slot_cls), .unit_free(free),
        .wb_vld(wb_vld), .wb_reg(wb_reg),
        .issue_cnt(issue_cnt), .pending(pending)
    );

    int checks = 0;
    int failures = 0;
    bit [NREG-1:0] m_pend = '0;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit live(input bit f, input int r);
        return f && (r != 0);
    endfunction

    // Behavioural reference for the issue count
    function automatic int ref_cnt();
        for (int i = 0; i < N; i++) begin
            if (!v[i]) return i;
            if (!free[cls[i]]) return i;
            if (live(sav[i], sa[i]) && m_pend[sa[i]]) return i;
            if (live(sbv[i], sb[i]) && m_pend[sb[i]]) return i;
            if (live(dv[i], dd[i]) && m_pend[dd[i]]) return i;
            for (int j = 0; j < i; j++) begin
                if (cls[i] == cls[j]) return i;
                if (live(dv[j], dd[j]) &&
                    ((live(sav[i], sa[i]) && sa[i] == dd[j]) ||
                     (live(sbv[i], sb[i]) && sb[i] == dd[j]))) return i;
                if (live(dv[i], dd[i]) && live(dv[j], dd[j]) && dd[i] == dd[j]) return i;
                if (live(dv[i], dd[i]) &&
                    ((live(sav[j], sa[j]) && sa[j] == dd[i]) ||
                     (live(sbv[j], sb[j]) && sb[j] == dd[i]))) return i;
            end
        end
        return N;
    endfunction

    task automatic clear_inputs();
        for (int i = 0; i < N; i++) begin
            v[i] = 0; sa[i] = 0; sb[i] = 0; dd[i] = 0;
            sav[i] = 0; sbv[i] = 0; dv[i] = 0; cls[i] = CW'(i);
        end
        for (int k = 0; k < WB; k++) begin wbv[k] = 0; wbr[k] = 0; end
        free = '1;
    endtask

    task automatic put(input int i, input int a, input bit av, input int b, input bit bv,
                       input int d, input bit ddv, input int c);
        v[i] = 1; sa[i] = RW'(a); sav[i] = av; sb[i] = RW'(b); sbv[i] = bv;
        dd[i] = RW'(d); dv[i] = ddv; cls[i] = CW'(c);
    endtask

    // One cycle: compare count before the edge, pending after it
    task automatic step(input int lit, input string tag);
        int exp;
        bit [NREG-1:0] setv, clrv;
        #1;
        exp = ref_cnt();
        check("R1 model count", issue_cnt, exp);
        if (lit >= 0) check(tag, issue_cnt, lit);
        setv = '0; clrv = '0;
        for (int i = 0; i < exp; i++) if (live(dv[i], dd[i])) setv[dd[i]] = 1;
        for (int k = 0; k < WB; k++) if (wbv[k]) clrv[wbr[k]] = 1;
        @(posedge clk);
        #1;
        m_pend = (m_pend & ~clrv) | setv;
        check("R7 model pending", pending, m_pend);
    endtask

    task automatic drain();
        while (m_pend != '0) begin
            int k;
            clear_inputs();
            k = 0;
            for (int r = 0; r < NREG; r++) begin
                if (m_pend[r] && k < WB) begin wbv[k] = 1; wbr[k] = RW'(r); k++; end
            end
            step(-1, "");
        end
        clear_inputs();
    endtask

    initial begin
        #2_000_000;
        failures++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check("R7 reset pending", pending, 0);
        step(0, "R1 empty group");

        // R1: fully independent group issues all four
        put(0, 5, 1, 6, 1, 1, 1, 0); put(1, 7, 1, 8, 1, 2, 1, 1);
        put(2, 9, 1, 10, 1, 3, 1, 2); put(3, 11, 1, 12, 1, 4, 1, 3);
        step(4, "R1 independent group");
        check("R7 targets pending", pending[4:1], 4'hF);
        drain();

        // R2: slot 2 reads slot 0 target
        put(0, 5, 1, 6, 1, 1, 1, 0); put(1, 7, 1, 8, 1, 2, 1, 1);
        put(2, 1, 1, 10, 1, 3, 1, 2); put(3, 11, 1, 12, 1, 4, 1, 3);
        step(2, "R2 group RAW");
        drain();

        // R3: slot 1 writes slot 0 target
        put(0, 5, 1, 6, 1, 1, 1, 0); put(1, 7, 1, 8, 1, 1, 1, 1);
        put(2, 9, 1, 10, 1, 3, 1, 2);
        step(1, "R3 group WAW");
        drain();

        // R4: slot 3 overwrites slot 1 second source
        put(0, 5, 1, 6, 1, 1, 1, 0); put(1, 7, 1, 8, 1, 2, 1, 1);
        put(2, 9, 1, 10, 1, 3, 1, 2); put(3, 11, 1, 12, 1, 8, 1, 3);
        step(3, "R4 group WAR");
        drain();

        // R5: make r9 pending, then read it and write it
        put(0, 5, 1, 6, 1, 9, 1, 0);
        step(1, "R5 setup issue");
        clear_inputs();
        put(0, 5, 1, 6, 1, 1, 1, 0); put(1, 9, 1, 8, 1, 2, 1, 1);
        step(1, "R5 in-flight source");
        drain();
        put(0, 5, 1, 6, 1, 9, 1, 0);
        step(1, "R5 setup issue");
        clear_inputs();
        put(0, 5, 1, 6, 1, 9, 1, 0);
        step(0, "R5 in-flight target");

        // R10: writeback of r9 in the same cycle does not release the read
        clear_inputs();
        put(0, 9, 1, 6, 1, 1, 1, 0);
        wbv[0] = 1; wbr[0] = 9;
        step(0, "R10 same-cycle writeback");
        check("R7 writeback clears", pending[9], 0);
        wbv[0] = 0;
        step(1, "R10 next cycle issues");
        drain();

        // R6: busy class and duplicated class
        put(0, 5, 1, 6, 1, 1, 1, 0); put(1, 7, 1, 8, 1, 2, 1, 2);
        free = 4'b1011;
        step(1, "R6 unit busy");
        drain();
        put(0, 5, 1, 6, 1, 1, 1, 1); put(1, 7, 1, 8, 1, 2, 1, 0);
        put(2, 9, 1, 10, 1, 3, 1, 1);
        step(2, "R6 same class twice");
        drain();

        // R8: matching registers with valid flags cleared
        put(0, 5, 1, 6, 0, 1, 1, 0); put(1, 1, 0, 8, 1, 2, 1, 1);
        put(2, 9, 1, 10, 1, 6, 1, 2); put(3, 11, 1, 12, 1, 3, 0, 3);
        step(4, "R8 invalid operands ignored");
        check("R8 no set without valid target", pending[3], 0);
        drain();
        // R1: an empty slot cuts the group
        put(0, 5, 1, 6, 1, 1, 1, 0); put(2, 9, 1, 10, 1, 3, 1, 2);
        v[1] = 0;
        step(1, "R1 hole in group");
        drain();

        // R9: register zero in every role
        put(0, 5, 1, 6, 1, 0, 1, 0); put(1, 0, 1, 0, 1, 2, 1, 1);
        put(2, 9, 1, 10, 1, 0, 1, 2); put(3, 0, 1, 12, 1, 4, 1, 3);
        step(4, "R9 zero register free");
        check("R9 zero never pending", pending[0], 0);
        drain();

        // R7: set wins over a same-cycle clear
        put(0, 5, 1, 6, 1, 7, 1, 0);
        wbv[1] = 1; wbr[1] = 7;
        step(1, "R7 issue with clear");
        check("R7 set beats clear", pending[7], 1);
        drain();

        // Random phase, small register range to crowd hazards
        for (int n = 0; n < 400; n++) begin
            clear_inputs();
            for (int i = 0; i < N; i++) begin
                v[i]   = ($urandom % 8) != 0;
                sa[i]  = RW'($urandom % 8);  sav[i] = $urandom % 2;
                sb[i]  = RW'($urandom % 8);  sbv[i] = $urandom % 2;
                dd[i]  = RW'($urandom % 8);  dv[i]  = ($urandom % 4) != 0;
                cls[i] = CW'($urandom % 4);
            end
            free = NCLASS'($urandom);
            for (int k = 0; k < WB; k++) begin
                wbv[k] = $urandom % 2;
                wbr[k] = RW'($urandom % 8);
            end
            step(-1, "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule